// File: doc/BRIEF.md
# Link Power Mode Controller

This block chooses the power mode of a video link redriver and drives the enables for its data-lane receivers, its clock-lane receiver, its transmitters and its DDC path. Four inputs steer it: an output-enable pin, the sink-side hot-plug level, a control bit that allows automatic standby, and a raw activity indication from the clock-lane squelch detector. A free-running reference clock times everything. The block also repeats the hot-plug level toward the source and controls the high-Z state of the transmit outputs.

Standby has two stages. In the idle stage only the clock-lane receiver runs, and the block waits for any activity at all, noise included. The first activity edge opens a qualification window of a fixed number of reference cycles, 4 microseconds by default at 100 MHz. During the window the block counts activity edges. Enough edges mean a real clock is present and the block enters normal operation; too few send it back to idle. If the clock lane goes quiet for a set time in normal operation, the block drops back to the idle stage.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While output-enable is low the mode is power-down, whatever the other inputs are. All four path enables are 0, `tx_hiz_o` is 1 and `hpd_src_oe_o` is 0.
- R2: `mode_o` reports the current mode as 2'b00 power-down, 2'b01 standby idle, 2'b10 standby qualify, 2'b11 normal.
- R3: With output-enable high, the auto-standby bit clear and sink hot-plug low, the mode is power-down. A drop of sink hot-plug in any mode under these conditions returns the block to power-down.
- R4: With output-enable high and the auto-standby bit set, the sink hot-plug level has no effect on the mode. A block in power-down moves to standby idle whichever level sink hot-plug has.
- R5: In both standby stages the data receivers and transmitters are disabled, `tx_hiz_o` is 1, and the clock-lane receiver and the DDC path are enabled.
- R6: In standby idle, any edge (rising or falling) of the synchronized activity signal moves the block to standby qualify. Without an edge it stays in idle.
- R7: Standby qualify lasts exactly QUAL_CYCLES reference cycles. Edges seen during those cycles are counted. The block then enters normal mode if the count reached MIN_EDGES, and otherwise returns to idle. The edge that opened the window is not counted.
- R8: In normal mode all four path enables are 1 and `tx_hiz_o` is 0.
- R9: In normal mode, LOSS_CYCLES consecutive cycles without an activity edge return the block to standby idle. Activity that keeps going holds it in normal mode.
- R10: While output-enable is high, `hpd_src_oe_o` is 1 and `hpd_src_o` follows the sink hot-plug level.
- R11: Every asynchronous input passes through a two-flop synchronizer. An input change sampled at one reference edge shows on `mode_o` after the third rising edge. It does not show after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Output-enable pin (asynchronous) |
| hpd_snk_i | input | 1 | Sink hot-plug level (asynchronous) |
| auto_sb_i | input | 1 | Auto-standby control bit; when set, sink hot-plug is ignored |
| clk_act_i | input | 1 | Raw clock-lane activity from the squelch detector (asynchronous) |
| data_rx_en_o | output | 1 | Enable for the three data-lane receivers |
| clk_rx_en_o | output | 1 | Enable for the clock-lane receiver |
| tx_en_o | output | 1 | Enable for the transmitters |
| tx_hiz_o | output | 1 | Transmit outputs high-Z |
| ddc_en_o | output | 1 | Enable for the DDC path |
| hpd_src_o | output | 1 | Source-side hot-plug level |
| hpd_src_oe_o | output | 1 | Drive enable for the source hot-plug pin; 0 means high-Z |
| mode_o | output | 2 | Encoded current mode (see R2) |

## Verification
The sharpest corner is the edge-count threshold. Bursts of exactly MIN_EDGES and MIN_EDGES minus one counted edges must split between normal and idle. A design that counts the edge opening the window, or that compares with > instead of >=, lands on the wrong side of that split. Random burst lengths also cover every stage between idle and normal. The silence timeout is exercised both ways: continuous activity must hold normal mode, and a quiet lane must drop it, so a timer that never clears or never expires shows up. A hot-plug drop while in normal mode, the auto-standby bit masking hot-plug, and an exact synchronizer latency check each catch their own mistake: a missing power-down path, a hot-plug qualifier that ignores the control bit, and a synchronizer that is one flop short or one flop long.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_QUAL = 2'b10,
        MODE_RUN  = 2'b11
    } mode_e;
endpackage

// File: rtl/link_pwr_sync.sv
module link_pwr_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, hold_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d_i;
            hold_q <= meta_q;
        end
    end

    assign q_o = hold_q;
endmodule

// File: rtl/link_pwr_fsm.sv
module link_pwr_fsm
    import link_pwr_pkg::*;
#(
    parameter int QUAL_CYCLES = 400,
    parameter int MIN_EDGES   = 16,
    parameter int LOSS_CYCLES = 64
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  oe_i,
    input  logic  hpd_i,
    input  logic  auto_i,
    input  logic  act_i,
    output mode_e mode_o
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam int LW = $clog2(LOSS_CYCLES + 1);

    typedef struct packed {
        mode_e         mode;
        logic          act_prev;
        logic [QW-1:0] qtmr;
        logic [EW-1:0] ecnt;
        logic [LW-1:0] quiet;
    } fsm_t;

    fsm_t st_d, st_q;
    logic edge_seen, allowed;
    logic [EW-1:0] ecnt_nx;

    always_comb begin
        st_d          = st_q;
        st_d.act_prev = act_i;
        edge_seen     = act_i ^ st_q.act_prev;
        allowed       = oe_i && (auto_i || hpd_i);
        ecnt_nx       = st_q.ecnt;
        if (edge_seen && st_q.ecnt < EW'(MIN_EDGES)) ecnt_nx = st_q.ecnt + 1'b1;

        if (!allowed) begin
            st_d.mode  = MODE_OFF;
            st_d.qtmr  = '0;
            st_d.ecnt  = '0;
            st_d.quiet = '0;
        end else begin
            unique case (st_q.mode)
                MODE_OFF: st_d.mode = MODE_IDLE;
                MODE_IDLE: begin
                    if (edge_seen) begin
                        st_d.mode = MODE_QUAL;
                        st_d.qtmr = '0;
                        st_d.ecnt = '0;
                    end
                end
                MODE_QUAL: begin
                    st_d.qtmr = st_q.qtmr + 1'b1;
                    st_d.ecnt = ecnt_nx;
                    if (st_q.qtmr == QW'(QUAL_CYCLES - 1)) begin
                        st_d.mode  = (ecnt_nx >= EW'(MIN_EDGES)) ? MODE_RUN : MODE_IDLE;
                        st_d.qtmr  = '0;
                        st_d.quiet = '0;
                    end
                end
                MODE_RUN: begin
                    if (edge_seen) begin
                        st_d.quiet = '0;
                    end else if (st_q.quiet == LW'(LOSS_CYCLES - 1)) begin
                        st_d.mode  = MODE_IDLE;
                        st_d.quiet = '0;
                    end else begin
                        st_d.quiet = st_q.quiet + 1'b1;
                    end
                end
                default: st_d.mode = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_OFF, act_prev: 1'b0, qtmr: '0, ecnt: '0, quiet: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // R1: output-enable low forces power-down
    assert_oe_low_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_i |=> st_q.mode == MODE_OFF);

    // R3: hot-plug low with auto-standby clear forces power-down
    assert_hpd_low_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_i && !auto_i && !hpd_i) |=> st_q.mode == MODE_OFF);

    // R6: idle never reaches qualify without an activity edge
    assert_idle_needs_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_IDLE && act_i == st_q.act_prev) |=> st_q.mode != MODE_QUAL);

    // R7: qualify holds until its window ends
    assert_qual_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_QUAL && allowed && st_q.qtmr != QW'(QUAL_CYCLES - 1))
        |=> st_q.mode == MODE_QUAL);

    // R7: normal mode is entered only from qualify
    assert_run_from_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_RUN && $past(st_q.mode) != MODE_RUN) |-> $past(st_q.mode) == MODE_QUAL);

    // R7: window timer stays in range
    assert_qtmr_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.qtmr < QW'(QUAL_CYCLES));

    // R9: activity edge in normal mode keeps it there
    assert_run_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_RUN && allowed && act_i != st_q.act_prev) |=> st_q.mode == MODE_RUN);
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import link_pwr_pkg::*;
#(
    parameter int QUAL_CYCLES = 400,
    parameter int MIN_EDGES   = 16,
    parameter int LOSS_CYCLES = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       oe_i,
    input  logic       hpd_snk_i,
    input  logic       auto_sb_i,
    input  logic       clk_act_i,
    output logic       data_rx_en_o,
    output logic       clk_rx_en_o,
    output logic       tx_en_o,
    output logic       tx_hiz_o,
    output logic       ddc_en_o,
    output logic       hpd_src_o,
    output logic       hpd_src_oe_o,
    output logic [1:0] mode_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic oe_s, hpd_s, auto_s, act_s;
    mode_e mode;

    assign raw_in = {oe_i, hpd_snk_i, auto_sb_i, clk_act_i};
    assign {oe_s, hpd_s, auto_s, act_s} = sync_out;

    link_pwr_sync #(.W(NSYNC)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    link_pwr_fsm #(
        .QUAL_CYCLES(QUAL_CYCLES),
        .MIN_EDGES  (MIN_EDGES),
        .LOSS_CYCLES(LOSS_CYCLES)
    ) u_fsm (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .oe_i  (oe_s),
        .hpd_i (hpd_s),
        .auto_i(auto_s),
        .act_i (act_s),
        .mode_o(mode)
    );

    always_comb begin
        data_rx_en_o = (mode == MODE_RUN);
        tx_en_o      = (mode == MODE_RUN);
        clk_rx_en_o  = (mode != MODE_OFF);
        ddc_en_o     = (mode != MODE_OFF);
        tx_hiz_o     = (mode != MODE_RUN);
        hpd_src_oe_o = oe_s;
        hpd_src_o    = oe_s & hpd_s;
        mode_o       = mode;
    end

    // R5: data receivers never run without the clock receiver
    assert_rx_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_rx_en_o |-> clk_rx_en_o);

    // R1: synchronized output-enable low turns the transmitters off next cycle
    assert_tx_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_s |=> !tx_en_o && !ddc_en_o);
endmodule

// File: tb/link_pwr_ctrl_bench.sv
module link_pwr_ctrl_bench;
    localparam int QC = 40;
    localparam int ME = 8;
    localparam int LC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oe = 1'b0, hpd = 1'b0, asb = 1'b0, act = 1'b0;
    logic data_rx_en, clk_rx_en, tx_en, tx_hiz, ddc_en, hpd_src, hpd_src_oe;
    logic [1:0] mode;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    link_pwr_ctrl #(.QUAL_CYCLES(QC), .MIN_EDGES(ME), .LOSS_CYCLES(LC)) u_link_pwr_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .hpd_snk_i(hpd), .auto_sb_i(asb),
        .clk_act_i(act), .data_rx_en_o(data_rx_en), .clk_rx_en_o(clk_rx_en),
        .tx_en_o(tx_en), .tx_hiz_o(tx_hiz), .ddc_en_o(ddc_en), .hpd_src_o(hpd_src),
        .hpd_src_oe_o(hpd_src_oe), .mode_o(mode)
    );

    // {data_rx, clk_rx, tx, hiz, ddc} expected for a mode code
    function automatic logic [4:0] exp_outs(input logic [1:0] m);
        case (m)
            2'b00:   return 5'b00010;
            2'b11:   return 5'b11101;
            default: return 5'b01011;
        endcase
    endfunction

    // burst of n toggles: first opens window, the other n-1 are counted
    function automatic logic [1:0] exp_after_burst(input int n);
        if (n == 0) return 2'b01;
        return (n - 1 >= ME) ? 2'b11 : 2'b01;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
        end
    endtask

    task automatic chk_mode(input string req, input logic [1:0] m);
        chk(req, {6'd0, mode}, {6'd0, m});
        chk(req, {3'd0, data_rx_en, clk_rx_en, tx_en, tx_hiz, ddc_en}, {3'd0, exp_outs(m)});
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            act = ~act;
            wait_n(2);
        end
    endtask

    initial begin
        void'($urandom(32'd4177));
        wait_n(3);
        chk_mode("R1 reset", 2'b00);
        chk("R1 reset hpd oe", {7'd0, hpd_src_oe}, 8'd0);
        rst_n = 1'b1;

        // R1: output-enable low, everything else asserted
        hpd = 1'b1; asb = 1'b1; act = 1'b1;
        wait_n(10);
        chk_mode("R1 oe low", 2'b00);
        chk("R1 hpd src hiz", {7'd0, hpd_src_oe}, 8'd0);

        // R3: oe high, auto clear, hpd low
        asb = 1'b0; hpd = 1'b0; oe = 1'b1;
        wait_n(10);
        chk_mode("R3 hpd low off", 2'b00);
        chk("R10 hpd follows low", {6'd0, hpd_src_oe, hpd_src}, 8'b10);

        // R2/R5: hpd rises -> standby idle
        hpd = 1'b1;
        wait_n(6);
        chk_mode("R2 R5 idle", 2'b01);
        chk("R10 hpd follows high", {6'd0, hpd_src_oe, hpd_src}, 8'b11);

        // R4: auto set, hpd low stays idle
        asb = 1'b1; wait_n(4); hpd = 1'b0;
        wait_n(8);
        chk_mode("R4 hpd ignored", 2'b01);
        chk("R10 hpd follows auto", {6'd0, hpd_src_oe, hpd_src}, 8'b10);

        // R6: single toggle -> qualify; check at 5 cycles (3 latency)
        act = ~act;
        wait_n(5);
        chk_mode("R6 R2 qualify", 2'b10);
        wait_n(QC + 5);
        chk_mode("R7 no edges back idle", 2'b01);

        // R7 threshold boundary: 8 counted edges -> normal
        burst(ME + 1);
        wait_n(QC + 10 - 2 * (ME + 1));
        chk_mode("R7 R8 threshold met", 2'b11);
        // R9: sustained activity holds normal
        for (int i = 0; i < 40; i++) begin act = ~act; wait_n(2); end
        chk_mode("R9 kept by activity", 2'b11);
        wait_n(LC + 10);
        chk_mode("R9 silence to idle", 2'b01);

        // R7: one edge short
        burst(ME);
        wait_n(QC + 10 - 2 * ME);
        chk_mode("R7 threshold missed", 2'b01);

        // R3: hot-plug drop in normal with auto clear
        asb = 1'b0; hpd = 1'b1; wait_n(5);
        burst(ME + 3);
        wait_n(QC + 10 - 2 * (ME + 3));
        chk_mode("R3 precondition normal", 2'b11);
        hpd = 1'b0;
        for (int i = 0; i < 3; i++) begin act = ~act; wait_n(2); end
        chk_mode("R3 hpd drop off", 2'b00);

        // R11: latency of oe
        hpd = 1'b1; wait_n(5);
        burst(ME + 2);
        wait_n(QC + 10 - 2 * (ME + 2));
        chk_mode("R11 precondition normal", 2'b11);
        oe = 1'b0;
        wait_n(2);
        chk("R11 not yet", {6'd0, mode}, 8'd3);
        wait_n(1);
        chk("R11 after three", {6'd0, mode}, 8'd0);
        wait_n(5);
        chk_mode("R1 oe drop", 2'b00);

        // random bursts
        oe = 1'b1;
        for (int it = 0; it < 14; it++) begin
            int n;
            asb = 1'($urandom_range(0, 1));
            hpd = asb ? 1'($urandom_range(0, 1)) : 1'b1;
            wait_n(8);
            chk_mode("R4 R6 random start idle", 2'b01);
            n = $urandom_range(0, 16);
            burst(n);
            wait_n(QC + 10 - 2 * n);
            chk_mode("R7 random burst", exp_after_burst(n));
            wait_n(LC + 40);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule